// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter for a Block-Transfer Engine

This block decides who drives the system bus: the host processor, the block-transfer engine, or a higher-priority DMA master. The host writes a control word that holds a run/busy bit and an exclusive-mode bit. Setting the run bit starts a transfer. The bit stays set until the engine's sequencer signals completion, and an interrupt output follows it exactly. Clearing the bit mid-transfer pauses the engine, and setting it again resumes the transfer.

In shared mode the engine and the host take turns on the bus in slices of `SLICE_CYCLES` bus cycles, counted on a bus-cycle strobe. Whoever does not own the bus waits: the host through a halt request, the engine through a withdrawn grant. In exclusive mode the engine keeps the bus until the transfer ends. In both modes the engine steps aside for a higher-priority DMA request. Ownership only ever changes at a bus-cycle boundary. If the host rewrites the run bit during its own slice, the engine reclaims the bus at the next boundary instead of waiting for the slice to run out.

Top module: `bus_share_arb`

## Requirements
- R1: After reset, run/busy, exclusive, interrupt, grant and halt are all 0, and the slice count is 0.
- R2: A control write with the run bit 1, while `lines_zero` is 0, sets busy in the next cycle. `irq_o` always equals `busy_o`. The write also loads the exclusive bit from `cfg_excl`.
- R3: A control write with the run bit 1 while `lines_zero` is 1 leaves busy at 0, and the engine is never granted.
- R4: `xfer_done` clears busy in the next cycle unless a control write happens in the same cycle, in which case the write wins. Once busy is clear, the engine releases the bus at the next boundary and `host_halt_o` falls.
- R5: Ownership (`eng_grant_o`, `host_halt_o`) changes only at a clock edge where `cyc_end` is 1. The slice count is 0 in the first cycle of any new owner.
- R6: Once busy has been set by a write, the engine is granted at the first boundary where `dma_req` is 0, and its slice count starts at 0.
- R7: In shared mode with busy held, the engine owns the bus for exactly `SLICE_CYCLES` strobes. The host then owns it for `SLICE_CYCLES` strobes, and the two keep alternating. `host_halt_o` is 1 exactly when the host does not own the bus.
- R8: A run-bit write of 1 during the host's slice returns the bus to the engine at the next boundary, whatever the slice count is.
- R9: In exclusive mode with busy held and no DMA request, the engine keeps the bus for any number of strobes. The slice count holds.
- R10: When `dma_req` is 1 at a boundary, the engine's grant drops while `host_halt_o` stays 1. The engine regains the bus at the first boundary where `dma_req` is 0, provided busy is still set.
- R11: A run-bit write of 0 pauses the engine: the grant drops at the next boundary. A later write of 1 resumes it.
- R12: `slice_cnt_o` counts the strobes completed in the current slice and never reaches `SLICE_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Host control-word write strobe |
| cfg_busy | input | 1 | Run/busy bit of the written word |
| cfg_excl | input | 1 | Exclusive-mode bit of the written word |
| lines_zero | input | 1 | Line count of the pending transfer is zero |
| xfer_done | input | 1 | Transfer-complete pulse from the sequencer |
| dma_req | input | 1 | Higher-priority DMA master request |
| cyc_end | input | 1 | Bus-cycle boundary strobe |
| busy_o | output | 1 | Run/busy bit readback |
| excl_o | output | 1 | Exclusive-mode bit readback |
| irq_o | output | 1 | Interrupt, equal to busy |
| eng_grant_o | output | 1 | Engine owns the bus |
| host_halt_o | output | 1 | Host must stay off the bus |
| slice_cnt_o | output | CNT_W | Strobes completed in the current slice |

## Verification
A slice counter that is off by one shows up as a grant edge one strobe early or late, and this becomes visible within a single slice of a long shared-mode sweep. A missing restart or yield path leaves the grant at the wrong value on the very next boundary after the write or the request. A busy bit that is cleared or set wrongly appears on `busy_o` and `irq_o` one cycle after the causing input.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_HOST   = 2'd0,
    OWN_ENGINE = 2'd1,
    OWN_YIELD  = 2'd2
  } owner_e;

  // effective run bit of a host write: a zero-length transfer never starts
  function automatic logic run_accept(input logic wr_busy, input logic no_lines);
    return wr_busy & ~no_lines;
  endfunction

  function automatic logic host_visible_halt(input owner_e o);
    return o != OWN_HOST;
  endfunction
endpackage

// File: rtl/arb_ctrl_reg.sv
module arb_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_busy,
  input  logic cfg_excl,
  input  logic lines_zero,
  input  logic xfer_done,
  output logic busy,
  output logic excl,
  output logic start_evt
);
  import arb_pkg::*;

  logic accepted;
  assign accepted  = run_accept(cfg_busy, lines_zero);
  assign start_evt = cfg_wr & accepted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      excl <= 1'b0;
    end else begin
      if (cfg_wr) begin
        busy <= accepted;
        excl <= cfg_excl;
      end else if (xfer_done) begin
        busy <= 1'b0;
      end
    end
  end

  AST_ZERO_LINES_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_busy && lines_zero |=> !busy); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !cfg_wr |=> !busy); // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && start_evt |=> busy); // R4
endmodule

// File: rtl/arb_slice_timer.sv
module arb_slice_timer #(
  parameter int SLICE_CYCLES = 64,
  localparam int CNT_W = (SLICE_CYCLES > 1) ? $clog2(SLICE_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  function automatic logic at_limit(input logic [CNT_W-1:0] v);
    return v == CNT_W'(SLICE_CYCLES - 1);
  endfunction

  assign last = at_limit(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (adv)       cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SLICE_CYCLES - 1)); // R12
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !adv |=> $stable(cnt)); // R9
endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            excl,
  input  logic            start_evt,
  input  logic            dma_req,
  input  logic            cyc_end,
  input  logic            slice_last,
  output arb_pkg::owner_e owner,
  output logic            handoff,
  output logic            slice_adv
);
  import arb_pkg::*;

  owner_e nxt;
  logic   kick;

  function automatic owner_e next_owner(
    input owner_e cur, input logic b, input logic ex, input logic k,
    input logic dreq, input logic edge_now, input logic lst);
    owner_e r;
    r = cur;
    if (edge_now) begin
      case (cur)
        OWN_HOST:   if (b && !dreq && (k || ex || lst)) r = OWN_ENGINE;
        OWN_ENGINE: if (!b)                  r = OWN_HOST;
                    else if (dreq)           r = OWN_YIELD;
                    else if (!ex && lst)     r = OWN_HOST;
        OWN_YIELD:  if (!dreq)               r = b ? OWN_ENGINE : OWN_HOST;
        default:                             r = OWN_HOST;
      endcase
    end
    return r;
  endfunction

  assign nxt       = next_owner(owner, busy, excl, kick, dma_req, cyc_end, slice_last);
  assign handoff   = nxt != owner;
  assign slice_adv = cyc_end && !handoff && !slice_last &&
                     (((owner == OWN_ENGINE) && !excl) || ((owner == OWN_HOST) && busy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner <= OWN_HOST;
      kick  <= 1'b0;
    end else begin
      owner <= nxt;
      if (start_evt)     kick <= 1'b1;
      else if (handoff)  kick <= 1'b0;
      else if (!busy)    kick <= 1'b0;
    end
  end

  AST_OWNER_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(owner)); // R5
  AST_DMA_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    owner == OWN_ENGINE && dma_req && cyc_end |=> owner != OWN_ENGINE); // R10
  AST_EXCL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    owner == OWN_ENGINE && excl && busy && !dma_req && cyc_end |=> owner == OWN_ENGINE); // R9
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    owner == OWN_ENGINE && !busy && cyc_end |=> owner == OWN_HOST); // R11
  AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    owner == OWN_HOST && kick && busy && !dma_req && cyc_end |=> owner == OWN_ENGINE); // R8
endmodule

// File: rtl/bus_share_arb.sv
module bus_share_arb #(
  parameter int SLICE_CYCLES = 64,
  localparam int CNT_W = (SLICE_CYCLES > 1) ? $clog2(SLICE_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_busy,
  input  logic             cfg_excl,
  input  logic             lines_zero,
  input  logic             xfer_done,
  input  logic             dma_req,
  input  logic             cyc_end,
  output logic             busy_o,
  output logic             excl_o,
  output logic             irq_o,
  output logic             eng_grant_o,
  output logic             host_halt_o,
  output logic [CNT_W-1:0] slice_cnt_o
);
  import arb_pkg::*;

  logic   busy_q, excl_q, start_evt;
  logic   handoff, slice_adv, slice_last;
  owner_e owner;

  arb_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_busy(cfg_busy),
    .cfg_excl(cfg_excl), .lines_zero(lines_zero), .xfer_done(xfer_done),
    .busy(busy_q), .excl(excl_q), .start_evt(start_evt)
  );

  arb_slice_timer #(.SLICE_CYCLES(SLICE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(handoff), .adv(slice_adv),
    .cnt(slice_cnt_o), .last(slice_last)
  );

  arb_owner_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .busy(busy_q), .excl(excl_q),
    .start_evt(start_evt), .dma_req(dma_req), .cyc_end(cyc_end),
    .slice_last(slice_last), .owner(owner), .handoff(handoff),
    .slice_adv(slice_adv)
  );

  assign busy_o      = busy_q;
  assign excl_o      = excl_q;
  assign irq_o       = busy_q;
  assign eng_grant_o = owner == OWN_ENGINE;
  assign host_halt_o = host_visible_halt(owner);

  AST_FRESH_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(owner) |-> slice_cnt_o == '0); // R5
  AST_GRANT_HALTS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    eng_grant_o |-> host_halt_o); // R7
  AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !eng_grant_o |=> !eng_grant_o); // R3
endmodule

// File: tb/sim_bus_share_arb.sv
module sim_bus_share_arb;
  localparam int SLICE = 64;
  localparam int CW = $clog2(SLICE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_busy = 0, cfg_excl = 0, lines_zero = 0;
  logic xfer_done = 0, dma_req = 0, cyc_end = 0;
  logic busy_o, excl_o, irq_o, eng_grant_o, host_halt_o;
  logic [CW-1:0] slice_cnt_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_count = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bus_share_arb #(.SLICE_CYCLES(SLICE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_busy(cfg_busy),
    .cfg_excl(cfg_excl), .lines_zero(lines_zero), .xfer_done(xfer_done),
    .dma_req(dma_req), .cyc_end(cyc_end), .busy_o(busy_o), .excl_o(excl_o),
    .irq_o(irq_o), .eng_grant_o(eng_grant_o), .host_halt_o(host_halt_o),
    .slice_cnt_o(slice_cnt_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 100000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc_count);
      summary();
    end
  end

  // one clock; inputs set beforehand at a falling edge, sampled at the next
  task automatic step(input logic strobe);
    cyc_end = strobe;
    @(posedge clk);
    @(negedge clk);
    cyc_end = 0; cfg_wr = 0; xfer_done = 0;
  endtask

  task automatic wr(input logic b, input logic e);
    cfg_wr = 1; cfg_busy = b; cfg_excl = e;
    step(0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy_o, 0);
    chk("R1", "excl", excl_o, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "grant", eng_grant_o, 0);
    chk("R1", "halt", host_halt_o, 0);
    chk("R1", "cnt", slice_cnt_o, 0);

    // R3 zero-line start is refused
    lines_zero = 1;
    wr(1, 0);
    chk("R3", "busy", busy_o, 0);
    step(1);
    chk("R3", "grant", eng_grant_o, 0);
    lines_zero = 0;

    // R2 start
    wr(1, 0);
    chk("R2", "busy", busy_o, 1);
    chk("R2", "irq", irq_o, 1);
    for (int i = 0; i < 3; i++) begin
      step(0);
      chk("R5", "grant before strobe", eng_grant_o, 0);
    end
    step(1);
    chk("R6", "grant", eng_grant_o, 1);
    chk("R6", "cnt", slice_cnt_o, 0);

    // R7 / R12 shared-mode sweep
    for (int j = 1; j <= 326; j++) begin
      int eg;
      step(1);
      eg = ((j / SLICE) % 2 == 0) ? 1 : 0;
      chk("R7", "grant", eng_grant_o, eg);
      chk("R7", "halt", host_halt_o, eg);
      chk("R12", "cnt", slice_cnt_o, j % SLICE);
    end

    // R8 rewrite during the host slice
    wr(1, 0);
    chk("R8", "grant held until boundary", eng_grant_o, 0);
    step(1);
    chk("R8", "grant", eng_grant_o, 1);
    chk("R5", "cnt fresh", slice_cnt_o, 0);

    // R10 DMA yield
    dma_req = 1;
    for (int i = 0; i < 3; i++) begin
      step(0);
      chk("R10", "grant mid-cycle", eng_grant_o, 1);
    end
    step(1);
    chk("R10", "grant", eng_grant_o, 0);
    chk("R10", "halt", host_halt_o, 1);
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk("R10", "grant during dma", eng_grant_o, 0);
    end
    dma_req = 0;
    step(1);
    chk("R10", "grant back", eng_grant_o, 1);
    chk("R10", "cnt", slice_cnt_o, 0);

    // R11 pause and resume
    wr(0, 0);
    chk("R11", "busy", busy_o, 0);
    chk("R2", "irq", irq_o, 0);
    chk("R11", "grant until boundary", eng_grant_o, 1);
    step(1);
    chk("R11", "grant", eng_grant_o, 0);
    chk("R11", "halt", host_halt_o, 0);
    wr(1, 0);
    step(1);
    chk("R11", "resume grant", eng_grant_o, 1);

    // R9 exclusive mode
    wr(1, 1);
    chk("R2", "excl", excl_o, 1);
    for (int i = 0; i < 200; i++) begin
      step(1);
      chk("R9", "grant", eng_grant_o, 1);
      chk("R9", "halt", host_halt_o, 1);
    end
    chk("R9", "cnt held", slice_cnt_o, 0);

    // R4 completion
    xfer_done = 1;
    step(0);
    chk("R4", "busy", busy_o, 0);
    chk("R4", "irq", irq_o, 0);
    chk("R4", "grant until boundary", eng_grant_o, 1);
    step(1);
    chk("R4", "grant", eng_grant_o, 0);
    chk("R4", "halt", host_halt_o, 0);

    // R4 write wins over done
    xfer_done = 1;
    wr(1, 1);
    chk("R4", "write wins", busy_o, 1);
    step(1);
    chk("R9", "excl start grant", eng_grant_o, 1);

    finished = 1;
    summary();
  end
endmodule